// File: doc/BRIEF.md
# Row-Based Lane Sharing Crossbar

This block moves 32-bit values between the lanes of a 64-lane wavefront. Each destination lane takes its value from a source lane in its own 16-lane row. The source is chosen by one of eight routing operations. Each row is further split into four banks of four consecutive lanes.

The crossbar sits between the register read stage and the arithmetic stage of a vector pipeline. The caller supplies:
- the lane data;
- the current destination contents (old values);
- the execution mask;
- a routing operation with its argument;
- per-row and per-bank write enables;
- a narrow-mode flag that limits the wavefront to its first two rows;
- two policy bits that choose what a lane receives when its source is outside the row or inactive.

The result for all lanes is registered and presented one cycle later with a valid flag.

Top module: `lane_share_xbar`

## Requirements
- R1: `valid_o` equals `valid_i` of the previous cycle. `data_o` loads the computed lanes on the edge where `valid_i` is 1 and holds otherwise. After synchronous reset, `valid_o` and `data_o` are 0.
- R2: With `op_i`=0 (quad permute), lane position p within a row reads position `(p & ~3) | arg_i[2k+1:2k]`, where k = p mod 4.
- R3: With `op_i`=1, position p reads position 15-p of its row. With `op_i`=2, position p reads 7-p when p<8 and 23-p otherwise.
- R4: With `op_i`=3, every lane of a row reads the position given by `arg_i[3:0]`.
- R5: With `op_i`=4, position p reads position `p XOR arg_i[3:0]`.
- R6: With `op_i`=5, position p reads p+n. With `op_i`=6, position p reads p-n. Here n = `arg_i[3:0]`, and n=0 leaves data in place.
- R7: With `op_i`=7, position p reads position (p-n) mod 16, so no source ever leaves the row.
- R8: `row_mask_i` bit r enables lanes 16r..16r+15. A lane in a disabled row outputs its old value.
- R9: `bank_mask_i` bit b enables the lanes at positions 4b..4b+3 of every row. A lane in a disabled bank outputs its old value.
- R10: A shift whose source position falls outside 0..15 gives 0 when `bound_zero_i`=1. Otherwise the lane keeps its old value.
- R11: A source lane whose `exec_i` bit is 0 still supplies its data when `fetch_inactive_i`=1. When `fetch_inactive_i`=0, the R10 rule applies: 0 if `bound_zero_i`=1, otherwise the old value.
- R12: With `narrow_i`=1, lanes 32..63 keep their old values whatever `row_mask_i[3:2]` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Inputs carry an operation this cycle |
| op_i | input | 3 | Routing operation code (see R2..R7) |
| arg_i | input | 8 | Quad selects or 4-bit lane argument |
| row_mask_i | input | 4 | Per-row write enable |
| bank_mask_i | input | 4 | Per-bank write enable |
| narrow_i | input | 1 | Only rows 0 and 1 exist |
| bound_zero_i | input | 1 | Invalid or refused source gives zero |
| fetch_inactive_i | input | 1 | Read inactive source lanes as they are |
| exec_i | input | 64 | Active flag per lane |
| data_i | input | 2048 | Source data, lane l at bits 32l+31..32l |
| old_i | input | 2048 | Current destination values, same layout |
| valid_o | output | 1 | `data_o` was loaded on the last edge |
| data_o | output | 2048 | Routed lane values, same layout |

## Verification
The bench runs every shift and rotate amount from 0 to 15. A design that confuses left and right shifts, or that wraps a shift instead of flagging it, shows a mismatch in the boundary lanes of each row.

Random execution masks are crossed with both policy bits. This catches two kinds of error: treating an inactive source like an out-of-row one when fetching is allowed, and zeroing when the old value should survive.

Row, bank and narrow gating are randomised. This exposes gating that is keyed to the wrong lane bits or that ignores narrow mode in the upper rows.

A final mixed run drops `valid_i` at random to catch an output register that updates while idle.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  typedef enum logic [2:0] {
    OP_QPERM   = 3'd0,
    OP_MIRROR  = 3'd1,
    OP_HMIRROR = 3'd2,
    OP_SHARE   = 3'd3,
    OP_XMASK   = 3'd4,
    OP_SHL     = 3'd5,
    OP_SHR     = 3'd6,
    OP_ROR     = 3'd7
  } lsh_op_e;
endpackage

// File: rtl/lsh_src_index.sv
// Source position within a row for each destination position.
// The map is the same for every row, so it is built once.
module lsh_src_index #(
  parameter int ROW_LANES = 16,
  parameter int ARG_W     = 8,
  parameter int POS_W     = $clog2(ROW_LANES)
) (
  input  lsh_pkg::lsh_op_e                   op_i,
  input  logic [ARG_W-1:0]                   arg_i,
  output logic [ROW_LANES-1:0][POS_W-1:0]    src_pos_o,
  output logic [ROW_LANES-1:0]               oob_o
);
  import lsh_pkg::*;

  logic [POS_W-1:0] amt;
  assign amt = arg_i[POS_W-1:0];

  for (genvar p = 0; p < ROW_LANES; p++) begin : g_pos
    localparam logic [POS_W-1:0] PV = POS_W'(p);
    localparam int QS = 2 * (p % 4);
    logic [POS_W:0]   up_sum, dn_dif;
    logic [1:0]       qsel;
    logic [POS_W-1:0] pos_w;
    logic             oob_w;

    assign up_sum = {1'b0, PV} + {1'b0, amt};
    assign dn_dif = {1'b0, PV} - {1'b0, amt};
    assign qsel   = arg_i[QS +: 2];

    always_comb begin
      pos_w = PV;
      oob_w = 1'b0;
      case (op_i)
        OP_QPERM:   pos_w = {PV[POS_W-1:2], qsel};
        OP_MIRROR:  pos_w = ~PV;
        OP_HMIRROR: pos_w = PV ^ {1'b0, {(POS_W-1){1'b1}}};
        OP_SHARE:   pos_w = amt;
        OP_XMASK:   pos_w = PV ^ amt;
        OP_SHL: begin
          pos_w = up_sum[POS_W-1:0];
          oob_w = up_sum[POS_W];
        end
        OP_SHR: begin
          pos_w = dn_dif[POS_W-1:0];
          oob_w = dn_dif[POS_W];
        end
        OP_ROR:     pos_w = dn_dif[POS_W-1:0];
        default:    pos_w = PV;
      endcase
    end

    assign src_pos_o[p] = pos_w;
    assign oob_o[p]     = oob_w;
  end
endmodule

// File: rtl/lsh_lane_pick.sv
// Value selection for one destination lane: row mux, then validity and gating.
module lsh_lane_pick #(
  parameter int DW        = 32,
  parameter int ROW_LANES = 16,
  parameter int POS_W     = $clog2(ROW_LANES)
) (
  input  logic [ROW_LANES*DW-1:0] row_data_i,
  input  logic [ROW_LANES-1:0]    row_exec_i,
  input  logic [POS_W-1:0]        src_pos_i,
  input  logic                    oob_i,
  input  logic [DW-1:0]           old_i,
  input  logic                    en_i,
  input  logic                    bound_zero_i,
  input  logic                    fetch_inactive_i,
  output logic [DW-1:0]           val_o
);
  logic [DW-1:0] src_val, fallback;
  logic          src_live;

  assign src_val  = row_data_i[src_pos_i*DW +: DW];
  assign src_live = row_exec_i[src_pos_i];
  assign fallback = bound_zero_i ? '0 : old_i;

  always_comb begin
    if (!en_i)                               val_o = old_i;
    else if (oob_i)                          val_o = fallback;
    else if (src_live || fetch_inactive_i)   val_o = src_val;
    else                                     val_o = fallback;
  end
endmodule

// File: rtl/lsh_out_stage.sv
// Output register with valid flag; data loads only on valid cycles.
module lsh_out_stage #(
  parameter int W = 2048
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d_i;
    end
  end

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(q_o));
endmodule

// File: rtl/lane_share_xbar.sv
module lane_share_xbar #(
  parameter int LANES       = 64,
  parameter int DW          = 32,
  parameter int ROW_LANES   = 16,
  parameter int BANK_LANES  = 4,
  parameter int ARG_W       = 8,
  parameter int ROWS        = LANES / ROW_LANES,
  parameter int BANKS       = ROW_LANES / BANK_LANES,
  parameter int NARROW_ROWS = ROWS / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_i,
  input  logic [2:0]            op_i,
  input  logic [ARG_W-1:0]      arg_i,
  input  logic [ROWS-1:0]       row_mask_i,
  input  logic [BANKS-1:0]      bank_mask_i,
  input  logic                  narrow_i,
  input  logic                  bound_zero_i,
  input  logic                  fetch_inactive_i,
  input  logic [LANES-1:0]      exec_i,
  input  logic [LANES*DW-1:0]   data_i,
  input  logic [LANES*DW-1:0]   old_i,
  output logic                  valid_o,
  output logic [LANES*DW-1:0]   data_o
);
  import lsh_pkg::*;

  localparam int POS_W = $clog2(ROW_LANES);
  localparam int ROW_W = ROW_LANES * DW;

  lsh_op_e                         op_e;
  logic [ROW_LANES-1:0][POS_W-1:0] src_pos;
  logic [ROW_LANES-1:0]            oob;
  logic [LANES*DW-1:0]             routed;

  assign op_e = lsh_op_e'(op_i);

  lsh_src_index #(.ROW_LANES(ROW_LANES), .ARG_W(ARG_W), .POS_W(POS_W)) u_index (
    .op_i      (op_e),
    .arg_i     (arg_i),
    .src_pos_o (src_pos),
    .oob_o     (oob)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int  R     = l / ROW_LANES;
    localparam int  P     = l % ROW_LANES;
    localparam int  B     = P / BANK_LANES;
    localparam bit  UPPER = (R >= NARROW_ROWS);
    logic en;

    assign en = row_mask_i[R] & bank_mask_i[B] & ~(narrow_i & UPPER);

    lsh_lane_pick #(.DW(DW), .ROW_LANES(ROW_LANES), .POS_W(POS_W)) u_pick (
      .row_data_i       (data_i[R*ROW_W +: ROW_W]),
      .row_exec_i       (exec_i[R*ROW_LANES +: ROW_LANES]),
      .src_pos_i        (src_pos[P]),
      .oob_i            (oob[P]),
      .old_i            (old_i[l*DW +: DW]),
      .en_i             (en),
      .bound_zero_i     (bound_zero_i),
      .fetch_inactive_i (fetch_inactive_i),
      .val_o            (routed[l*DW +: DW])
    );
  end

  lsh_out_stage #(.W(LANES*DW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .d_i     (routed),
    .valid_o (valid_o),
    .q_o     (data_o)
  );

  assert_row_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !row_mask_i[0]) |=> (data_o[DW-1:0] == $past(old_i[DW-1:0])));
  assert_bank_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !bank_mask_i[0]) |=> (data_o[DW-1:0] == $past(old_i[DW-1:0])));
  assert_narrow_keep_R12: assert property (@(posedge clk) disable iff (rst)
    (valid_i && narrow_i) |=>
      (data_o[LANES*DW-1 -: DW] == $past(old_i[LANES*DW-1 -: DW])));
  assert_oob_shift_only_R10: assert property (@(posedge clk) disable iff (rst)
    (oob != '0) |-> (op_e == OP_SHL || op_e == OP_SHR));
endmodule

// File: tb/test_lane_share_xbar.sv
`timescale 1ns/1ps
module test_lane_share_xbar;
  localparam int LANES = 64;
  localparam int DW    = 32;

  logic clk = 1'b0;
  logic rst;
  always #10 clk = ~clk;

  logic [LANES*DW-1:0] data_i, old_i, data_o;
  logic [LANES-1:0]    exec_i;
  logic [2:0]          op_i;
  logic [7:0]          arg_i;
  logic [3:0]          row_mask_i, bank_mask_i;
  logic narrow_i, bound_zero_i, fetch_inactive_i, valid_i, valid_o;

  lane_share_xbar i_lane_share_xbar (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .arg_i(arg_i),
    .row_mask_i(row_mask_i), .bank_mask_i(bank_mask_i), .narrow_i(narrow_i),
    .bound_zero_i(bound_zero_i), .fetch_inactive_i(fetch_inactive_i),
    .exec_i(exec_i), .data_i(data_i), .old_i(old_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  logic [31:0] din [LANES];
  logic [31:0] dold[LANES];
  bit          ex  [LANES];
  int t_op, t_arg, t_rm, t_bm;
  bit t_nar, t_bz, t_fi, t_v;

  logic [LANES*DW-1:0] exp_data;
  bit exp_valid;
  int checks = 0;
  int fails  = 0;

  task automatic apply();
    for (int d = 0; d < LANES; d++) begin
      data_i[d*DW +: DW] = din[d];
      old_i[d*DW +: DW]  = dold[d];
      exec_i[d]          = ex[d];
    end
    op_i = 3'(t_op); arg_i = 8'(t_arg);
    row_mask_i = 4'(t_rm); bank_mask_i = 4'(t_bm);
    narrow_i = t_nar; bound_zero_i = t_bz; fetch_inactive_i = t_fi; valid_i = t_v;
  endtask

  // Behavioural expectation for one lane from the requirements.
  function automatic logic [31:0] ref_lane(int d);
    int r = d / 16;
    int p = d % 16;
    int n = t_arg & 15;
    int s = p;
    bit bad = 0;
    case (t_op)
      0: s = (p / 4) * 4 + ((t_arg >> (2 * (p % 4))) & 3);
      1: s = 15 - p;
      2: s = (p < 8) ? 7 - p : 23 - p;
      3: s = n;
      4: s = p ^ n;
      5: begin s = p + n; bad = (s > 15); end
      6: begin s = p - n; bad = (s < 0); end
      default: s = (p - n + 16) % 16;
    endcase
    if (t_nar && r >= 2) return dold[d];
    if (((t_rm >> r) & 1) == 0 || ((t_bm >> (p / 4)) & 1) == 0) return dold[d];
    if (bad) return t_bz ? 32'd0 : dold[d];
    if (ex[r*16 + s] || t_fi) return din[r*16 + s];
    return t_bz ? 32'd0 : dold[d];
  endfunction

  task automatic compare(string tag);
    checks++;
    if (valid_o !== exp_valid) begin
      fails++;
      $display("FAIL %s valid_o: got %0b expected %0b", tag, valid_o, exp_valid);
    end else if (data_o !== exp_data) begin
      fails++;
      for (int d = 0; d < LANES; d++) begin
        if (data_o[d*DW +: DW] !== exp_data[d*DW +: DW]) begin
          $display("FAIL %s lane %0d: got %h expected %h", tag, d,
                   data_o[d*DW +: DW], exp_data[d*DW +: DW]);
          break;
        end
      end
    end
  endtask

  // One cycle: check last result, then drive new inputs and predict.
  task automatic step(string tag, int op, bit rrow, bit rbank, bit rexec,
                      int nar, int bz, int fi, bit rvalid, int amt);
    @(negedge clk);
    compare(tag);
    for (int d = 0; d < LANES; d++) begin
      din[d]  = $urandom;
      dold[d] = $urandom;
      ex[d]   = rexec ? bit'($urandom % 2) : 1'b1;
    end
    t_op  = (op < 0)  ? int'($urandom % 8)   : op;
    t_arg = (amt < 0) ? int'($urandom % 256) : amt;
    t_rm  = rrow  ? int'($urandom % 16) : 15;
    t_bm  = rbank ? int'($urandom % 16) : 15;
    t_nar = (nar < 0) ? bit'($urandom % 2) : bit'(nar);
    t_bz  = (bz < 0)  ? bit'($urandom % 2) : bit'(bz);
    t_fi  = (fi < 0)  ? bit'($urandom % 2) : bit'(fi);
    t_v   = rvalid ? ($urandom % 4 != 0) : 1'b1;
    apply();
    if (t_v)
      for (int d = 0; d < LANES; d++) exp_data[d*DW +: DW] = ref_lane(d);
    exp_valid = t_v;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    for (int d = 0; d < LANES; d++) begin din[d] = '0; dold[d] = '0; ex[d] = 1'b1; end
    t_op = 0; t_arg = 0; t_rm = 15; t_bm = 15;
    t_nar = 0; t_bz = 0; t_fi = 0; t_v = 0;
    apply();
    exp_data = '0; exp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1 reset");

    for (int i = 0; i < 24; i++) step("R2 quad permute", 0, 0, 0, 0, 0, 0, 0, 0, -1);
    for (int i = 0; i < 12; i++) step("R3 row mirror",   1, 0, 0, 0, 0, 0, 0, 0, -1);
    for (int i = 0; i < 12; i++) step("R3 half mirror",  2, 0, 0, 0, 0, 0, 0, 0, -1);
    for (int i = 0; i < 16; i++) step("R4 row share",    3, 0, 0, 0, 0, 0, 0, 0, -1);
    for (int i = 0; i < 16; i++) step("R5 xor mask",     4, 0, 0, 0, 0, 0, 0, 0, -1);
    for (int n = 0; n < 16; n++) step("R6 shift left",   5, 0, 0, 0, 0, 0, 0, 0, n);
    for (int n = 0; n < 16; n++) step("R6 shift right",  6, 0, 0, 0, 0, 1, 0, 0, n);
    for (int n = 0; n < 16; n++) step("R7 rotate right", 7, 0, 0, 0, 0, 1, 0, 0, n);
    for (int i = 0; i < 32; i++)
      step("R10 out of row", 5 + int'($urandom % 2), 0, 0, 0, 0, -1, 0, 0, -1);
    for (int i = 0; i < 32; i++) step("R8 row mask",  -1, 1, 0, 0, 0, -1, 0, 0, -1);
    for (int i = 0; i < 32; i++) step("R9 bank mask", -1, 0, 1, 0, 0, -1, 0, 0, -1);
    for (int i = 0; i < 40; i++) step("R11 inactive", -1, 0, 0, 1, 0, -1, -1, 0, -1);
    for (int i = 0; i < 24; i++) step("R12 narrow",   -1, 0, 0, 1, 1, -1, -1, 0, -1);
    for (int i = 0; i < 100; i++) step("R1 mixed",    -1, 1, 1, 1, -1, -1, -1, 1, -1);
    @(negedge clk);
    compare("R1 final");
    finish_run();
  end
endmodule